// File: doc/BRIEF.md
# Postfix Expression Evaluator

This unit evaluates an arithmetic expression written in postfix order. Tokens arrive one per clock over a valid/ready handshake. Each token is a number, an operator (add, subtract or multiply) or an end marker. Numbers go onto an internal last-in-first-out store of sixteen entries. An operator removes the top two entries, combines them and puts the result back. The end marker removes the single remaining entry and presents it as the result.

Every access to the store is guarded. A push into a full store, a pop from an empty one, or an expression that leaves other than one value at its end produces a one-cycle error pulse with a code instead of a result. After either outcome the store is emptied and the unit waits for a fresh expression.

Top module: `postfix_eval`

## Requirements
- R1: After reset `tok_ready` is 1, `res_valid` and `err_valid` are 0 and the store is empty. A token is accepted on a clock edge where `tok_valid` and `tok_ready` are both 1. The token kind field is 00 number, 01 operator, 10 end, and 11 is reserved.
- R2: An operator pops the right operand first and the left operand second, then pushes left op right. Operator code 00 adds, 01 subtracts (left minus right) and 10 multiplies. All values are 16-bit two's complement and wrap modulo 2^16.
- R3: A number accepted while sixteen values are already stored ends the expression with `err_code` 01.
- R4: A pop attempted by an operator while the store is empty ends the expression with `err_code` 10.
- R5: After an operator is accepted, `tok_ready` is 0 for exactly four cycles (pop, pop, compute, push) and then returns to 1.
- R6: An end token accepted while exactly one value is stored raises `res_valid` for one cycle, starting with the edge that accepts the token, with that value on `res_data`.
- R7: An end token accepted while the store holds zero or more than one value, a token of kind 11, or an operator with code 11 ends the expression with `err_code` 11.
- R8: After a result or an error the store is empty and `tok_ready` is 1, so the next expression starts from nothing.
- R9: `res_valid` and `err_valid` are never high together, each pulse lasts one cycle, and `err_code` is non-zero while `err_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Unit can take a token this cycle |
| tok_kind | input | 2 | Token kind: 00 number, 01 operator, 10 end, 11 reserved |
| tok_op | input | 2 | Operator code: 00 add, 01 subtract, 10 multiply |
| tok_data | input | 16 | Number value for kind 00 |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Result value, meaningful with `res_valid` |
| err_valid | output | 1 | One-cycle error strobe |
| err_code | output | 2 | 01 overflow, 10 underflow, 11 malformed |

## Verification
The nested expression 8 3 4 + * shows that intermediate results re-enter the store and sit below later operands. Subtraction with the smaller value first, and a product that exceeds 16 bits, tell the right-operand order and the wrap width apart from their mirror images. Filling all sixteen entries and reducing them tells a correct full limit from an off-by-one, and the error cases are each followed by a clean expression to show that the store really was emptied.

// File: rtl/postfix_pkg.sv
package postfix_pkg;

    typedef enum logic [1:0] {
        TK_NUM  = 2'b00,
        TK_OPR  = 2'b01,
        TK_END  = 2'b10,
        TK_RSVD = 2'b11
    } tok_kind_e;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_MUL  = 2'b10,
        OP_RSVD = 2'b11
    } op_code_e;

    typedef enum logic [1:0] {
        EC_NONE  = 2'b00,
        EC_OVER  = 2'b01,
        EC_UNDER = 2'b10,
        EC_FORM  = 2'b11
    } err_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POP_R,
        ST_POP_L,
        ST_CALC,
        ST_PUSH
    } eval_state_e;

    function automatic logic [15:0] apply_op(input op_code_e op,
                                             input logic [15:0] lhs,
                                             input logic [15:0] rhs);
        logic [31:0] prod;
        prod = lhs * rhs;
        case (op)
            OP_ADD:  return lhs + rhs;
            OP_SUB:  return lhs - rhs;
            OP_MUL:  return prod[15:0];
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/pf_stack.sv
module pf_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  top,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] wr_idx;
    logic [AW-1:0] top_idx;

    assign wr_idx  = AW'(cnt_q);
    assign top_idx = AW'(cnt_q - CW'(1));
    assign top     = mem[top_idx];
    assign cnt     = cnt_q;
    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && wr_idx == AW'(g))
                mem[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (push && !full)
            cnt_q <= cnt_q + CW'(1);
        else if (pop && !empty)
            cnt_q <= cnt_q - CW'(1);
    end
endmodule

// File: rtl/pf_alu.sv
module pf_alu
    import postfix_pkg::*;
#(
    parameter int W = 16
) (
    input  op_code_e     op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res
);
    always_comb res = apply_op(op, lhs, rhs);
endmodule

// File: rtl/postfix_eval.sv
module postfix_eval
    import postfix_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tok_valid,
    output logic         tok_ready,
    input  logic [1:0]   tok_kind,
    input  logic [1:0]   tok_op,
    input  logic [W-1:0] tok_data,
    output logic         res_valid,
    output logic [W-1:0] res_data,
    output logic         err_valid,
    output logic [1:0]   err_code
);
    eval_state_e   st_q, st_d;
    op_code_e      op_q;
    logic [W-1:0]  rhs_q, lhs_q, acc_q, alu_res;
    logic          accept;
    logic          stk_push, stk_pop, stk_clr, stk_full, stk_empty;
    logic [W-1:0]  stk_wdata, stk_top;
    logic [CW-1:0] stk_cnt;
    logic          fire_done, fire_err;
    err_code_e     fire_code;

    assign tok_ready = (st_q == ST_IDLE);
    assign accept    = tok_valid && tok_ready;

    pf_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .clr   (stk_clr),
        .push  (stk_push),
        .pop   (stk_pop),
        .wdata (stk_wdata),
        .top   (stk_top),
        .cnt   (stk_cnt),
        .full  (stk_full),
        .empty (stk_empty)
    );

    pf_alu #(.W(W)) u_alu (
        .op  (op_q),
        .lhs (lhs_q),
        .rhs (rhs_q),
        .res (alu_res)
    );

    always_comb begin
        st_d      = st_q;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        stk_wdata = tok_data;
        fire_done = 1'b0;
        fire_err  = 1'b0;
        fire_code = EC_NONE;
        case (st_q)
            ST_IDLE: if (accept) begin
                case (tok_kind_e'(tok_kind))
                    TK_NUM: begin
                        if (stk_full) begin
                            fire_err  = 1'b1;
                            fire_code = EC_OVER;
                        end else begin
                            stk_push = 1'b1;
                        end
                    end
                    TK_OPR: begin
                        if (op_code_e'(tok_op) == OP_RSVD) begin
                            fire_err  = 1'b1;
                            fire_code = EC_FORM;
                        end else begin
                            st_d = ST_POP_R;
                        end
                    end
                    TK_END: begin
                        if (stk_cnt == CW'(1)) begin
                            stk_pop   = 1'b1;
                            fire_done = 1'b1;
                        end else begin
                            fire_err  = 1'b1;
                            fire_code = EC_FORM;
                        end
                    end
                    default: begin
                        fire_err  = 1'b1;
                        fire_code = EC_FORM;
                    end
                endcase
            end
            ST_POP_R, ST_POP_L: begin
                if (stk_empty) begin
                    fire_err  = 1'b1;
                    fire_code = EC_UNDER;
                    st_d      = ST_IDLE;
                end else begin
                    stk_pop = 1'b1;
                    st_d    = (st_q == ST_POP_R) ? ST_POP_L : ST_CALC;
                end
            end
            ST_CALC: st_d = ST_PUSH;
            ST_PUSH: begin
                stk_push  = 1'b1;
                stk_wdata = acc_q;
                st_d      = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign stk_clr = fire_done || fire_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            op_q      <= OP_ADD;
            rhs_q     <= '0;
            lhs_q     <= '0;
            acc_q     <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
            err_valid <= 1'b0;
            err_code  <= EC_NONE;
        end else begin
            st_q      <= st_d;
            res_valid <= fire_done;
            err_valid <= fire_err;
            err_code  <= fire_code;
            if (fire_done)
                res_data <= stk_top;
            if (st_q == ST_IDLE && accept && tok_kind == TK_OPR)
                op_q <= op_code_e'(tok_op);
            if (st_q == ST_POP_R && !stk_empty)
                rhs_q <= stk_top;
            if (st_q == ST_POP_L && !stk_empty)
                lhs_q <= stk_top;
            if (st_q == ST_CALC)
                acc_q <= alu_res;
        end
    end
endmodule

// File: rtl/postfix_eval_chk.sv
module postfix_eval_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          tok_valid,
    input logic          tok_ready,
    input logic [1:0]    tok_kind,
    input logic [1:0]    tok_op,
    input logic          res_valid,
    input logic          err_valid,
    input logic [1:0]    err_code,
    input logic [CW-1:0] stk_cnt
);
    // R5: an accepted operator takes the unit out of the ready state
    assert_busy_after_op_R5: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_ready && tok_kind == 2'b01 && tok_op != 2'b11) |=> !tok_ready);

    // R9: result and error strobes are exclusive
    assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && err_valid));

    // R9: result strobe lasts one cycle
    assert_res_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R9: error strobe lasts one cycle with a real code
    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid);
    assert_err_code_R9: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> err_code != 2'b00);

    // R3: the store never holds more than its depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        stk_cnt <= CW'(DEPTH));

    // R8: any outcome leaves an empty, ready unit
    assert_cleared_after_outcome_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid || err_valid) |-> (stk_cnt == '0 && tok_ready));
endmodule

bind postfix_eval postfix_eval_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tok_valid (tok_valid),
    .tok_ready (tok_ready),
    .tok_kind  (tok_kind),
    .tok_op    (tok_op),
    .res_valid (res_valid),
    .err_valid (err_valid),
    .err_code  (err_code),
    .stk_cnt   (stk_cnt)
);

// File: tb/tb_postfix_eval.sv
module tb_postfix_eval;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tok_valid = 1'b0;
    logic        tok_ready;
    logic [1:0]  tok_kind = 2'b00;
    logic [1:0]  tok_op = 2'b00;
    logic [15:0] tok_data = '0;
    logic        res_valid;
    logic [15:0] res_data;
    logic        err_valid;
    logic [1:0]  err_code;

    int n_tests = 0;
    int n_fail  = 0;
    int n_res   = 0;
    int n_err   = 0;
    logic [15:0] last_res;
    logic [1:0]  last_err;
    bit finished = 0;

    localparam logic [1:0] K_NUM = 2'b00, K_OPR = 2'b01, K_END = 2'b10, K_BAD = 2'b11;
    localparam logic [1:0] O_ADD = 2'b00, O_SUB = 2'b01, O_MUL = 2'b10, O_BAD = 2'b11;

    always #10 clk = ~clk;

    postfix_eval dut (
        .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_kind(tok_kind), .tok_op(tok_op), .tok_data(tok_data),
        .res_valid(res_valid), .res_data(res_data),
        .err_valid(err_valid), .err_code(err_code)
    );

    always @(negedge clk) begin
        if (res_valid) begin n_res++; last_res = res_data; end
        if (err_valid) begin n_err++; last_err = err_code; end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] k, input logic [1:0] o, input logic [15:0] d);
        @(negedge clk);
        while (!tok_ready) @(negedge clk);
        tok_valid = 1'b1; tok_kind = k; tok_op = o; tok_data = d;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic num(input logic [15:0] d); put(K_NUM, 2'b00, d); endtask
    task automatic opr(input logic [1:0] o);  put(K_OPR, o, '0);    endtask
    task automatic fin();                      put(K_END, 2'b00, '0); endtask

    task automatic begin_expr();
        repeat (2) @(negedge clk);
        n_res = 0; n_err = 0; last_res = '0; last_err = '0;
    endtask

    task automatic settle(); repeat (8) @(negedge clk); endtask

    task automatic expect_result(input string tag, input logic [15:0] v);
        settle();
        check({tag, " result count"}, n_res, 1);
        check({tag, " error count"}, n_err, 0);
        check({tag, " value"}, last_res, v);
    endtask

    task automatic expect_error(input string tag, input logic [1:0] c);
        settle();
        check({tag, " result count"}, n_res, 0);
        check({tag, " error count"}, n_err, 1);
        check({tag, " code"}, last_err, c);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 ready after reset", tok_ready, 1);
        check("R1 res_valid after reset", res_valid, 0);
        check("R1 err_valid after reset", err_valid, 0);
    endtask

    task automatic t_nested(); // R2, R6: 8 3 4 + * = 56
        begin_expr();
        num(8); num(3); num(4); opr(O_ADD); opr(O_MUL); fin();
        expect_result("R2 R6 8 3 4 + *", 16'd56);
    endtask

    task automatic t_sub_order(); // R2: left minus right
        begin_expr();
        num(10); num(4); opr(O_SUB); fin();
        expect_result("R2 10 4 -", 16'd6);
        begin_expr();
        num(3); num(5); opr(O_SUB); fin();
        expect_result("R2 3 5 - wraps", 16'hFFFE);
    endtask

    task automatic t_mul_wrap(); // R2: 300*300 = 90000 mod 65536
        begin_expr();
        num(300); num(300); opr(O_MUL); fin();
        expect_result("R2 300 300 *", 16'd24464);
    endtask

    task automatic t_op_timing(); // R5
        int lows;
        begin_expr();
        num(2); num(3);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = K_OPR; tok_op = O_ADD;
        @(negedge clk);
        tok_valid = 1'b0;
        lows = 0;
        while (!tok_ready && lows < 20) begin lows++; @(negedge clk); end
        check("R5 ready low cycles", lows, 4);
        fin();
        expect_result("R5 2 3 +", 16'd5);
    endtask

    task automatic t_end_timing(); // R6: strobe right after the accepting edge
        begin_expr();
        num(77);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = K_END;
        @(negedge clk);
        tok_valid = 1'b0;
        check("R6 res_valid after end", res_valid, 1);
        check("R6 res_data after end", res_data, 77);
        @(negedge clk);
        check("R6 res_valid one cycle", res_valid, 0);
    endtask

    task automatic t_full_ok(); // R3 boundary: exactly sixteen is fine
        begin_expr();
        for (int i = 1; i <= 16; i++) num(16'(i));
        for (int i = 0; i < 15; i++) opr(O_ADD);
        fin();
        expect_result("R3 sixteen values summed", 16'd136);
    endtask

    task automatic t_overflow(); // R3, R8
        begin_expr();
        for (int i = 0; i < 17; i++) num(16'(i));
        expect_error("R3 seventeenth push", 2'b01);
        check("R8 ready after overflow", tok_ready, 1);
        begin_expr();
        num(2); num(3); opr(O_ADD); fin();
        expect_result("R8 clean after overflow", 16'd5);
    endtask

    task automatic t_underflow(); // R4, R8
        begin_expr();
        num(5); opr(O_ADD);
        expect_error("R4 one operand", 2'b10);
        begin_expr();
        opr(O_MUL);
        expect_error("R4 no operand", 2'b10);
        begin_expr();
        num(9); fin();
        expect_result("R8 clean after underflow", 16'd9);
    endtask

    task automatic t_malformed(); // R7, R8
        begin_expr();
        num(1); num(2); fin();
        expect_error("R7 two left at end", 2'b11);
        begin_expr();
        fin();
        expect_error("R7 none left at end", 2'b11);
        begin_expr();
        num(1); put(K_BAD, 2'b00, '0);
        expect_error("R7 reserved kind", 2'b11);
        begin_expr();
        num(1); num(2); opr(O_BAD);
        expect_error("R7 reserved operator", 2'b11);
        begin_expr();
        num(4); fin();
        expect_result("R8 clean after malformed", 16'd4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_nested();
        t_sub_order();
        t_mul_wrap();
        t_op_timing();
        t_end_timing();
        t_full_ok();
        t_overflow();
        t_underflow();
        t_malformed();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule